// File: doc/BRIEF.md
# Dual-Output Event-Action PWM Generator

This block produces two pulse-width-modulated outputs from one shared timebase. A counter runs either downward from a programmable period value to zero and reloads, or up from zero to the period value and back down again, which gives center-aligned waveforms. The counter value is compared each cycle against zero, the period value and two compare thresholds. Every match becomes a one-cycle event pulse. A compare match is tagged with the direction in which the counter was moving.

Each output has its own table of two-bit actions, one per event. The table says what the output does when that event fires: hold, toggle, force low or force high. A fixed priority settles events that land in the same cycle. This lets one counter produce edge-aligned or center-aligned pulses, overlapping or disjoint pairs, and toggling patterns, all without extra logic around the block.

Top module: `pwm_event_gen`

## Requirements
- R1: While `rst_n` is low (synchronous), both PWM outputs become 0 and the direction flag becomes 0. The counter starts at `period` in count-down mode and at 0 in up/down mode. No event fires while `enable` is low.
- R2: With `updown_mode`=0, each enabled cycle moves the counter down by one. From 0 it reloads `period`. The period is therefore `period`+1 cycles, with one zero event and one load event in each period.
- R3: With `updown_mode`=1 and `period`>0, the counter rises from 0 to `period` and then falls back to 0, for a period of 2×`period` cycles. `cnt_dir` is 1 exactly when the step that produced the current count was upward. If `period` is 0, the counter stays at 0.
- R4: A compare event takes the direction of the step into the current count. In count-down mode, only the down-qualified compare actions are ever applied.
- R5: Each action table is 12 bits wide. Bits [1:0] hold the zero action and [3:2] the load action. Bits [5:4] and [7:6] hold the compare-A up and down actions, and [9:8] and [11:10] the compare-B up and down actions. The codes are 00 hold, 01 toggle, 10 force low and 11 force high. An action takes effect on the output one clock after its event is visible.
- R6: A zero or load event discards any compare event in the same cycle: `ev_cmpa` and `ev_cmpb` stay low, and the compare actions are not applied. When zero and load fire together, the zero action is the one applied.
- R7: When compare A and compare B fire in the same cycle, `pwm_a` applies only its compare-A action and `pwm_b` applies only its compare-B action.
- R8: While `enable` is low, the counter and both outputs hold and every event output is 0.
- R9: In up/down mode, suppose `pwm_a` is set to go high on compare-A up and low on compare-A down, with all other actions set to hold, and `cmp_a` < `period`. Then `pwm_a` is high for 2×(`period`−`cmp_a`) cycles in each period, centered on the load point. The same holds for `pwm_b` with compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Counting and event enable |
| updown_mode | input | 1 | 0 = count-down, 1 = up/down |
| period | input | CW | Counter turning/reload value |
| cmp_a | input | CW | Compare threshold A |
| cmp_b | input | CW | Compare threshold B |
| act_a | input | 12 | Action table for pwm_a |
| act_b | input | 12 | Action table for pwm_b |
| pwm_a | output | 1 | First PWM output |
| pwm_b | output | 1 | Second PWM output |
| ev_zero | output | 1 | Counter-at-zero event |
| ev_load | output | 1 | Counter-at-period event |
| ev_cmpa | output | 1 | Compare A event (after masking) |
| ev_cmpb | output | 1 | Compare B event (after masking) |
| cnt_dir | output | 1 | 1 when the last step was upward |

## Verification
The assertions check single-step properties on every cycle. They cover the ±1 step of the up/down counter, the reload after zero in count-down mode, a force-high zero action winning over a coinciding compare, a discarded compare leaving the output untouched, the A/B separation on coinciding matches, and the freeze while disabled. Properties that span whole periods need the bench scenarios, compared cycle by cycle against a behavioural model: period length, the number of event pulses, center-aligned pulse widths, toggle cadence and the degenerate zero-period case.

// File: rtl/pwm_event_gen.sv
module pwm_event_gen #(
  parameter int CW = 16,
  localparam int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          updown_mode,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [AW-1:0] act_a,
  input  logic [AW-1:0] act_b,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          ev_zero,
  output logic          ev_load,
  output logic          ev_cmpa,
  output logic          ev_cmpb,
  output logic          cnt_dir
);
  localparam logic [1:0] ACT_HOLD = 2'b00;
  localparam logic [1:0] ACT_TOG  = 2'b01;
  localparam logic [1:0] ACT_LOW  = 2'b10;
  localparam logic [1:0] ACT_HIGH = 2'b11;
  localparam int F_ZERO = 0, F_LOAD = 1, F_AUP = 2, F_ADN = 3, F_BUP = 4, F_BDN = 5;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          dir, dir_nxt;
  logic          going_up;
  logic [1:0]    code_a, code_b;

  function automatic logic apply(input logic cur, input logic [1:0] code);
    case (code)
      ACT_TOG:  return ~cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction

  function automatic logic [1:0] fld(input logic [AW-1:0] tbl, input int idx);
    return tbl[2*idx +: 2];
  endfunction

  assign going_up = dir & updown_mode;
  assign cnt_dir  = going_up;
  assign ev_zero  = enable && (cnt == '0);
  assign ev_load  = enable && (cnt == period);
  assign ev_cmpa  = enable && (cnt == cmp_a) && !ev_zero && !ev_load;
  assign ev_cmpb  = enable && (cnt == cmp_b) && !ev_zero && !ev_load;

  always_comb begin
    code_a = ACT_HOLD;
    if (ev_zero)      code_a = fld(act_a, F_ZERO);
    else if (ev_load) code_a = fld(act_a, F_LOAD);
    else if (ev_cmpa) code_a = fld(act_a, going_up ? F_AUP : F_ADN);
    else if (ev_cmpb) code_a = fld(act_a, going_up ? F_BUP : F_BDN);
  end

  always_comb begin
    code_b = ACT_HOLD;
    if (ev_zero)      code_b = fld(act_b, F_ZERO);
    else if (ev_load) code_b = fld(act_b, F_LOAD);
    else if (ev_cmpb) code_b = fld(act_b, going_up ? F_BUP : F_BDN);
    else if (ev_cmpa) code_b = fld(act_b, going_up ? F_AUP : F_ADN);
  end

  always_comb begin
    cnt_nxt = cnt;
    dir_nxt = dir;
    if (!updown_mode) begin
      dir_nxt = 1'b0;
      cnt_nxt = (cnt == '0) ? period : cnt - ONE;
    end else if (period == '0) begin
      dir_nxt = 1'b0;
      cnt_nxt = '0;
    end else if (cnt == '0) begin
      dir_nxt = 1'b1;
      cnt_nxt = ONE;
    end else if (cnt >= period) begin
      dir_nxt = 1'b0;
      cnt_nxt = cnt - ONE;
    end else begin
      cnt_nxt = dir ? cnt + ONE : cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= updown_mode ? '0 : period;
      dir   <= 1'b0;
      pwm_a <= 1'b0;
      pwm_b <= 1'b0;
    end else if (enable) begin
      cnt   <= cnt_nxt;
      dir   <= dir_nxt;
      pwm_a <= apply(pwm_a, code_a);
      pwm_b <= apply(pwm_b, code_b);
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && updown_mode && cnt != '0 && cnt < period |=>
      (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !updown_mode && cnt == '0 |=> cnt == $past(period));

  p_zero_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enable && cnt == '0 && act_a[1:0] == ACT_HIGH |=> pwm_a);

  p_cmp_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enable && cnt == period && cnt != '0 && cnt == cmp_a && cnt != cmp_b &&
    act_a[3:2] == ACT_HOLD |=> $stable(pwm_a));

  p_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmpa && ev_cmpb && act_a[5:4] == ACT_HOLD && act_a[7:6] == ACT_HOLD |=> $stable(pwm_a));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(pwm_a) && $stable(pwm_b) && $stable(cnt));
endmodule

// File: tb/sim_pwm_event_gen.sv
`timescale 1ns/1ps
module sim_pwm_event_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, en = 1'b0, mode = 1'b0;
  logic [15:0] ldv = 16'd5, ca_v = 16'd3, cb_v = 16'd1;
  logic [11:0] ta = '0, tb = '0;
  logic pwm_a, pwm_b, ev_zero, ev_load, ev_cmpa, ev_cmpb, cnt_dir;

  pwm_event_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .updown_mode(mode), .period(ldv),
    .cmp_a(ca_v), .cmp_b(cb_v), .act_a(ta), .act_b(tb),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .ev_zero(ev_zero), .ev_load(ev_load),
    .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb), .cnt_dir(cnt_dir));

  integer checks = 0, fails = 0;
  bit     done = 0;
  string  tag = "R1";
  integer m_cnt = 0, m_dir = 0, m_pa = 0, m_pb = 0;
  integer e_z, e_l, e_a, e_b, e_up;

  task automatic chk(input string r, input integer act, input integer exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic integer fld(input logic [11:0] t, input integer i);
    return integer'(t[2*i +: 2]);
  endfunction

  function automatic integer act(input integer cur, input integer code);
    case (code)
      1: return 1 - cur;
      2: return 0;
      3: return 1;
      default: return cur;
    endcase
  endfunction

  function void model_events();
    e_z  = (en && m_cnt == 0) ? 1 : 0;
    e_l  = (en && m_cnt == integer'(ldv)) ? 1 : 0;
    e_a  = (en && m_cnt == integer'(ca_v) && !e_z && !e_l) ? 1 : 0;
    e_b  = (en && m_cnt == integer'(cb_v) && !e_z && !e_l) ? 1 : 0;
    e_up = (m_dir == 1 && mode) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    model_events();
    if (!rst_n) begin
      m_cnt = mode ? 0 : integer'(ldv);
      m_dir = 0; m_pa = 0; m_pb = 0;
    end else if (en) begin
      if (e_z)      m_pa = act(m_pa, fld(ta, 0));
      else if (e_l) m_pa = act(m_pa, fld(ta, 1));
      else if (e_a) m_pa = act(m_pa, fld(ta, e_up ? 2 : 3));
      else if (e_b) m_pa = act(m_pa, fld(ta, e_up ? 4 : 5));
      if (e_z)      m_pb = act(m_pb, fld(tb, 0));
      else if (e_l) m_pb = act(m_pb, fld(tb, 1));
      else if (e_b) m_pb = act(m_pb, fld(tb, e_up ? 4 : 5));
      else if (e_a) m_pb = act(m_pb, fld(tb, e_up ? 2 : 3));
      if (!mode) begin
        m_cnt = (m_cnt == 0) ? integer'(ldv) : m_cnt - 1; m_dir = 0;
      end else if (ldv == 0) begin
        m_cnt = 0; m_dir = 0;
      end else if (m_cnt == 0) begin
        m_cnt = 1; m_dir = 1;
      end else if (m_cnt >= integer'(ldv)) begin
        m_cnt = m_cnt - 1; m_dir = 0;
      end else begin
        m_cnt = m_dir ? m_cnt + 1 : m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      model_events();
      chk(tag, {pwm_a, pwm_b, ev_zero, ev_load, ev_cmpa, ev_cmpb, cnt_dir},
          {m_pa[0], m_pb[0], e_z[0], e_l[0], e_a[0], e_b[0], e_up[0]});
    end
  end

  task automatic cyc(input integer n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic measure(input integer n, output integer ha, output integer hb,
                         output integer nz, output integer nl, output integer nd,
                         output integer ta_edges);
    integer prev;
    ha = 0; hb = 0; nz = 0; nl = 0; nd = 0; ta_edges = 0;
    @(negedge clk);
    prev = pwm_a;
    for (int i = 0; i < n; i++) begin
      ha += pwm_a; hb += pwm_b; nz += ev_zero; nl += ev_load; nd += cnt_dir;
      if (pwm_a != prev) ta_edges++;
      prev = pwm_a;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    integer ha, hb, nz, nl, nd, ed, sa, sb, evs;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm_a after reset", pwm_a, 0);
    chk("R1 pwm_b after reset", pwm_b, 0);
    chk("R1 no event while disabled", ev_load + ev_zero, 0);
    cyc(1);
    en = 1'b1;
    @(negedge clk);
    chk("R1 down-mode start at period", ev_load, 1);

    // R2: count-down period and event pulses
    tag = "R2";
    ta = 12'b00_00_10_00_00_11;
    tb = 12'b11_00_00_00_01_00;
    cyc(2);
    measure(24, ha, hb, nz, nl, nd, ed);
    chk("R2 zero pulses in 24 cycles", nz, 4);
    chk("R2 load pulses in 24 cycles", nl, 4);

    // R4: up-qualified actions unused in count-down mode
    tag = "R4";
    ta = 12'b00_00_00_11_00_10;
    tb = 12'b00_11_00_00_00_10;
    cyc(18);
    measure(12, ha, hb, nz, nl, nd, ed);
    chk("R4 pwm_a never high", ha, 0);
    chk("R4 pwm_b never high", hb, 0);
    chk("R4 direction flag low", nd, 0);

    // R5: toggle action and hold action
    tag = "R5";
    ldv = 16'd3;
    ta = 12'b00_00_00_00_00_01;
    tb = 12'b00_00_00_00_00_00;
    cyc(6);
    sb = pwm_b;
    measure(16, ha, hb, nz, nl, nd, ed);
    chk("R5 toggles every 4 cycles", ed, 4);
    chk("R5 hold keeps pwm_b", hb, 16 * sb);

    // R3 / R9: up/down center-aligned pair
    tag = "R3";
    mode = 1'b1; ldv = 16'd8; ca_v = 16'd3; cb_v = 16'd6;
    ta = 12'b00_00_10_11_00_00;
    tb = 12'b10_11_00_00_00_00;
    cyc(24);
    tag = "R9";
    measure(32, ha, hb, nz, nl, nd, ed);
    chk("R3 zero pulses in two periods", nz, 2);
    chk("R3 load pulses in two periods", nl, 2);
    chk("R3 upward cycles in two periods", nd, 16);
    chk("R9 pwm_a width", ha, 20);
    chk("R9 pwm_b width", hb, 8);
    chk("R9 pwm_a edges", ed, 4);

    // R6: compare at load / zero discarded
    tag = "R6";
    ca_v = 16'd8; cb_v = 16'd0;
    ta = 12'b00_00_00_00_00_10;
    tb = 12'b00_00_00_00_00_10;
    cyc(17);
    ta = 12'b00_00_11_11_00_00;
    tb = 12'b11_11_00_00_00_00;
    measure(32, ha, hb, nz, nl, nd, ed);
    chk("R6 pwm_a untouched by masked compare", ha, 0);
    chk("R6 pwm_b untouched by masked compare", hb, 0);
    chk("R6 no compare A pulse", integer'(ev_cmpa), 0);
    ldv = 16'd0;
    ta = 12'b00_00_00_00_10_11;
    cyc(20);
    @(negedge clk);
    chk("R6 zero beats load", pwm_a, 1);
    chk("R6 zero and load together", ev_zero + ev_load, 2);
    chk("R3 zero period holds count", cnt_dir, 0);

    // R7: coinciding compares
    tag = "R7";
    ldv = 16'd8; ca_v = 16'd4; cb_v = 16'd4;
    ta = 12'b11_10_10_11_00_00;
    tb = 12'b10_11_11_10_00_00;
    cyc(24);
    measure(32, ha, hb, nz, nl, nd, ed);
    chk("R7 pwm_a follows A only", ha, 16);
    chk("R7 pwm_b follows B only", hb, 16);

    // R8: disable freezes everything
    tag = "R8";
    cyc(3);
    en = 1'b0;
    @(negedge clk);
    sa = pwm_a; sb = pwm_b;
    evs = 0;
    for (int i = 0; i < 10; i++) begin
      evs += ev_zero + ev_load + ev_cmpa + ev_cmpb;
      chk("R8 pwm_a frozen", pwm_a, sa);
      chk("R8 pwm_b frozen", pwm_b, sb);
      @(negedge clk);
    end
    chk("R8 no events while disabled", evs, 0);
    #1;
    en = 1'b1;
    cyc(20);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule